// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit decides, every cycle, where the two ALU operands of a five-stage in-order integer pipeline come from and whether the front of the pipeline must wait. Registers are read in decode and written in the last stage, so the only hazard it resolves is a read of a register that an older instruction has not yet written back. For each operand of the instruction in execute, it compares the source register number against the destinations of the two older instructions still in flight. It then picks the newest matching result or, if none matches, the register file value.

The unit has no storage of its own. A result leaving the ALU can be consumed by the very next instruction through the bypass path. Data from a load appears only at the end of the memory stage, so a load whose result is needed by the instruction directly behind it raises a stall. That stall freezes the program counter and the fetch/decode register and turns the decode/execute register into a bubble for one cycle. After that bubble, the load sits in writeback and its value reaches the dependent instruction through the second bypass path. The register file writes before it reads within a cycle, so a consumer three slots behind its producer needs no help at all. The `clk` and `rst_n` pins clock and qualify the embedded timing checks only.

Top module: `hz_fwd_ctrl`

## Requirements
- R1: An execute-stage operand whose register number equals the memory-stage destination, with the memory-stage write enable high, gets select code 2'b10.
- R2: An operand that matches the writeback-stage destination with its write enable high, and does not qualify under R1, gets select code 2'b01.
- R3: When both older stages write the operand's register, the memory-stage result (code 2'b10) wins.
- R4: With no qualifying match the select code is 2'b00 (register file); a matching destination whose write enable is low does not count as a match.
- R5: A source operand of register 0 always gets code 2'b00, whatever the older stages write.
- R6: `stall` is high when the execute-stage instruction is a load with write enable high, its destination is non-zero, and it equals either decode-stage source register.
- R7: A non-load producer in execute never causes a stall, even when a decode-stage source equals its destination.
- R8: A load whose destination is register 0 never causes a stall.
- R9: The two operands are resolved independently; each may take a different source in the same cycle.
- R10: Select code 2'b11 is never produced.
- R11: A load followed at once by a user costs exactly one stall cycle. In the next cycle (bubble in execute, load in memory) no stall is raised, and once the user reaches execute with the load in writeback, its operand takes code 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded timing checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_rs1 | input | AW | First source register of the decode-stage instruction |
| id_rs2 | input | AW | Second source register of the decode-stage instruction |
| ex_rs1 | input | AW | First source register of the execute-stage instruction |
| ex_rs2 | input | AW | Second source register of the execute-stage instruction |
| ex_rd | input | AW | Destination of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | AW | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | AW | Destination of the writeback-stage instruction |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| sel_a | output | 2 | Bypass select for operand A: 00 file, 01 writeback, 10 memory |
| sel_b | output | 2 | Bypass select for operand B, same coding |
| stall | output | 1 | Hold PC and fetch/decode, insert bubble into decode/execute |

## Verification
The bench builds the unit with its default register-number width of five bits, giving 32 architectural registers. That width brings both ends of the register space within reach: register 0, which must never bypass or stall, and register 31, the highest index, which must compare on all bits. A short pipeline walk drives a load followed by its user, and an ALU producer followed by three consumers, cycle by cycle. This shows the single bubble and the hand-off from the memory-stage path to the writeback path and then to the register file.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Operand source codes for the ALU input multiplexers
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/hz_src_bypass.sv
module hz_src_bypass #(
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    mem_rd,
  input  logic             mem_we,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_we,
  output hz_pkg::byp_sel_e sel
);
  import hz_pkg::*;

  logic src_live;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_live = |src;
    mem_hit  = src_live && mem_we && (mem_rd == src);
    wb_hit   = src_live && wb_we  && (wb_rd  == src);
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  // R10: the unused code never leaves the unit
  assert_sel_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11);

  // R5: register 0 is always read from the file
  assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SEL_RF));

  // R2: a writeback selection implies a writing writeback stage with that register
  assert_wb_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_WB) |-> (wb_we && (wb_rd == src)));

  // R3: a memory-stage writer to this register is never passed over
  assert_mem_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_rd == src) && (src != '0)) |-> (sel == SEL_MEM));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0][AW-1:0]  id_src,
  input  logic [AW-1:0]            ex_rd,
  input  logic                     ex_we,
  input  logic                     ex_load,
  output logic                     stall
);
  logic [NSRC-1:0] src_hit;
  logic            dst_live;

  always_comb dst_live = |ex_rd;

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    always_comb src_hit[i] = dst_live && (id_src[i] == ex_rd);
  end

  always_comb stall = ex_load && ex_we && (|src_hit);

  // R6: a stall is only ever caused by a writing load
  assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_load && ex_we));

  // R8: a load into register 0 never holds the front end
  assert_zero_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !stall);
endmodule

// File: rtl/hz_fwd_ctrl.sv
module hz_fwd_ctrl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          stall
);
  import hz_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] id_src;
  logic [NSRC-1:0][AW-1:0] ex_src;
  byp_sel_e                sel_w [NSRC];

  always_comb begin
    id_src[0] = id_rs1;
    id_src[1] = id_rs2;
    ex_src[0] = ex_rs1;
    ex_src[1] = ex_rs2;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_opnd
    hz_src_bypass #(.AW(AW)) u_byp (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (ex_src[i]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel_w[i])
    );
  end

  hz_load_use #(.AW(AW), .NSRC(NSRC)) u_lu (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_src  (id_src),
    .ex_rd   (ex_rd),
    .ex_we   (ex_we),
    .ex_load (ex_load),
    .stall   (stall)
  );

  always_comb begin
    sel_a = sel_w[0];
    sel_b = sel_w[1];
  end

  // R7: an ALU producer is always covered by bypassing
  assert_alu_nostall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> !stall);

  // R9: one operand's choice does not constrain the other's
  assert_opnd_indep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == ex_rs2) |-> (sel_a == sel_b));
endmodule

// File: tb/sim_hz_fwd_ctrl.sv
module sim_hz_fwd_ctrl;
  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_we, ex_load, mem_we, wb_we;
  logic [1:0]    sel_a, sel_b;
  logic          stall;

  int checks = 0;
  int errors = 0;

  hz_fwd_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [4:0] ers1;
    logic [4:0] ers2;
    logic [4:0] mrd;
    logic       mwe;
    logic [4:0] wrd;
    logic       wwe;
    logic [4:0] irs1;
    logic [4:0] irs2;
    logic [4:0] erd;
    logic       ewe;
    logic       eld;
    logic [1:0] xa;
    logic [1:0] xb;
    logic       xs;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  // fields: ex_rs1 ex_rs2 mem_rd mem_we wb_rd wb_we id_rs1 id_rs2 ex_rd ex_we ex_load | sel_a sel_b stall | req
  localparam vec_t VECS [NV] = '{
    '{5'd1, 5'd2, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0, 4'd1},   // R1 operand A
    '{5'd3, 5'd4, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0, 4'd1},   // R1 operand B
    '{5'd6, 5'd7, 5'd0, 1'b0, 5'd6, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 4'd2},   // R2 operand A
    '{5'd6, 5'd7, 5'd9, 1'b1, 5'd7, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b01, 1'b0, 4'd2},   // R2 operand B
    '{5'd8, 5'd8, 5'd8, 1'b1, 5'd8, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b10, 2'b10, 1'b0, 4'd3},   // R3 newest wins
    '{5'd31,5'd31,5'd31,1'b1, 5'd31,1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b10, 2'b10, 1'b0, 4'd3},   // R3 top register
    '{5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd4},   // R4 no write enables
    '{5'd5, 5'd6, 5'd5, 1'b0, 5'd5, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 4'd4},   // R4 disabled mem falls to wb
    '{5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd5},   // R5 register 0
    '{5'd11,5'd12,5'd12,1'b1, 5'd11,1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b01, 2'b10, 1'b0, 4'd9},   // R9 mixed sources
    '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 5'd9, 5'd3, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 4'd6},   // R6 first source
    '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd4, 5'd3, 5'd3, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 4'd6},   // R6 second source
    '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd4, 5'd5, 5'd3, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 4'd6},   // R6 no match
    '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 5'd3, 5'd3, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 4'd6},   // R6 load not writing
    '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 5'd3, 5'd3, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd7},   // R7 ALU producer
    '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 4'd8}    // R8 load into r0
  };

  task automatic drive(input logic [4:0] ers1, ers2, mrd, input logic mwe,
                       input logic [4:0] wrd, input logic wwe,
                       input logic [4:0] irs1, irs2, erd, input logic ewe, eld);
    ex_rs1 = ers1; ex_rs2 = ers2; mem_rd = mrd; mem_we = mwe;
    wb_rd = wrd; wb_we = wwe; id_rs1 = irs1; id_rs2 = irs2;
    ex_rd = erd; ex_we = ewe; ex_load = eld;
  endtask

  task automatic check(input string tag, input logic [1:0] xa, xb, input logic xs);
    checks++;
    if (sel_a !== xa || sel_b !== xb || stall !== xs) begin
      errors++;
      $display("FAIL %s: sel_a=%b sel_b=%b stall=%b expected sel_a=%b sel_b=%b stall=%b",
               tag, sel_a, sel_b, stall, xa, xb, xs);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step;
    #2 check("reset R4", 2'b00, 2'b00, 1'b0);
    step;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step;
      drive(VECS[i].ers1, VECS[i].ers2, VECS[i].mrd, VECS[i].mwe, VECS[i].wrd, VECS[i].wwe,
            VECS[i].irs1, VECS[i].irs2, VECS[i].erd, VECS[i].ewe, VECS[i].eld);
      #2 check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].xa, VECS[i].xb, VECS[i].xs);
    end

    // R11: load r1 then user of r1; pipeline walk
    step; drive(0, 0, 0, 0, 0, 0, 5'd1, 5'd5, 5'd1, 1'b1, 1'b1);   // load in EX, user in ID
    #2 check("R11 stall cycle", 2'b00, 2'b00, 1'b1);
    step; drive(0, 0, 5'd1, 1'b1, 0, 0, 5'd1, 5'd5, 0, 1'b0, 1'b0); // bubble in EX, load in MEM
    #2 check("R11 single bubble", 2'b00, 2'b00, 1'b0);
    step; drive(5'd1, 5'd5, 0, 1'b0, 5'd1, 1'b1, 5'd1, 5'd7, 5'd4, 1'b1, 1'b0); // user in EX, load in WB
    #2 check("R11 load data via writeback", 2'b01, 2'b00, 1'b0);

    // R1 R2 R4: ALU producer of r2 feeding three consumers in a row
    step; drive(0, 0, 0, 0, 0, 0, 5'd2, 5'd0, 5'd2, 1'b1, 1'b0);
    #2 check("R7 producer behind consumer", 2'b00, 2'b00, 1'b0);
    step; drive(5'd2, 5'd0, 5'd2, 1'b1, 0, 0, 5'd0, 5'd2, 5'd8, 1'b1, 1'b0);
    #2 check("R1 first consumer", 2'b10, 2'b00, 1'b0);
    step; drive(5'd0, 5'd2, 5'd8, 1'b1, 5'd2, 1'b1, 5'd2, 5'd0, 5'd9, 1'b1, 1'b0);
    #2 check("R2 second consumer", 2'b00, 2'b01, 1'b0);
    step; drive(5'd2, 5'd0, 5'd9, 1'b1, 5'd8, 1'b1, 0, 0, 0, 1'b0, 1'b0);
    #2 check("R4 third consumer reads file", 2'b00, 2'b00, 1'b0);

    step;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule